// File: doc/BRIEF.md
# UART power and enable controller

This block is the mode-control shell around a small asynchronous serial transceiver. It holds one 8-bit mode register. One bit powers the whole unit. A second bit enables the transmit direction and a third enables the receive direction. Clearing the power bit puts the operation domain into reset at once and stops it; that reset is released through a synchronizer. Each direction enable only resets its own section, and that reset is synchronous.

While the unit is unpowered, the serial output idles high and the serial input is masked to its idle level. Powering down also clears the receive status, the transmit busy state, two control flags and the receive buffer. The required order is power first, then the directions; to stop, the directions go first, then power. Breaking the stop order sets a sticky sequence-error flag. A plain 8N1 shifter in each direction, timed by a fixed clock divider, makes the gating visible at the pins.

Register map: address 0 is the mode register, address 1 holds the flags (bits 7:6), address 2 is status, address 3 is the receive buffer, and address 4 accepts the transmit byte.

Top module: `uart_pwr_ctrl`

## Requirements
- R1: After reset the mode register (address 0) reads 0x01: power is bit 7, transmit enable is bit 6 and receive enable is bit 5, all 0. Bits 4:0 are plain read/write storage.
- R2: While power is 0, `clk_run_o` is low and the operation domain is held in reset. After power is written to 1, `clk_run_o` rises on the second clock edge after the write edge.
- R3: While transmit enable is 0 or the unit is not running, `tx_rst_o` is high, `txd` stays high, and writes to address 4 start no frame.
- R4: While receive enable is 0 or the unit is not running, `rx_rst_o` is high and frames on `rxd` are not received: status bit 2 stays 0.
- R5: While power is 0, `txd` is high and activity on `rxd` is ignored. No status bit is set by it after power returns.
- R6: Clearing power clears status bits 0, 1, 2 and 4, the flags at address 1 bits 7:6, and the receive buffer, so each reads 0.
- R7: A direction enable written while power is 0 is stored and reads back. That direction stays inactive until power is 1 and the release has completed.
- R8: A mode write that clears power while an enable bit was 1 sets status bit 7 and still powers down. Bit 7 stays set until status is written with bit 7 = 1.
- R9: Clearing transmit enable mid-frame abandons the frame: `txd` is high one clock later and status bit 4 (transmit busy) reads 0.
- R10: A write to address 4 while transmit is active and idle sends start 0, eight data bits LSB first and stop 1, each bit lasting DIV clocks.
- R11: A received 8N1 frame loads address 3 and sets status bit 2, and reading address 3 clears bit 2. A frame that arrives while bit 2 is set sets bit 1 (overrun). A stop bit of 0 sets bit 0 (framing) and stores nothing. Writing status with bit 0 or bit 1 = 1 clears that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe, data valid the next cycle |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Registered read data |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |
| clk_run_o | output | 1 | High while the operation domain runs |
| tx_rst_o | output | 1 | Transmit section held in reset |
| rx_rst_o | output | 1 | Receive section held in reset |

## Verification
The bench builds the block with DIV = 4 and two synchronizer stages. With a 4-clock bit time, whole frames take about forty cycles. That lets many random loopback bytes, overrun and framing cases, and a mid-frame disable all fit in a short run. With two stages, the release delay after power-up is exactly two edges, and the bench checks it cycle by cycle.

// File: rtl/uart_pwr_pkg.sv
package uart_pwr_pkg;
  localparam int AW = 3;
  localparam logic [AW-1:0] A_MODE = 3'd0;
  localparam logic [AW-1:0] A_FLAG = 3'd1;
  localparam logic [AW-1:0] A_STAT = 3'd2;
  localparam logic [AW-1:0] A_RXB  = 3'd3;
  localparam logic [AW-1:0] A_TXB  = 3'd4;
  localparam int B_PWR = 7;
  localparam int B_TXE = 6;
  localparam int B_RXE = 5;
  localparam logic [7:0] MODE_RST = 8'h01;
  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_HOLD} rx_st_e;
endpackage

// File: rtl/uart_pwr_regs.sv
module uart_pwr_regs
  import uart_pwr_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          core_rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  output logic [7:0]    mode_o,
  output logic [1:0]    flags_o,
  output logic          seq_err_o
);
  logic wr_mode, wr_stat, wr_flag, bad_stop;

  assign wr_mode  = wr_en && (wr_addr == A_MODE);
  assign wr_stat  = wr_en && (wr_addr == A_STAT);
  assign wr_flag  = wr_en && (wr_addr == A_FLAG);
  // power falls while a direction was still enabled
  assign bad_stop = wr_mode && mode_o[B_PWR] && !wr_data[B_PWR]
                    && (mode_o[B_TXE] || mode_o[B_RXE]);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_o    <= MODE_RST;
      seq_err_o <= 1'b0;
    end else begin
      if (wr_mode) mode_o <= wr_data;
      if (bad_stop) seq_err_o <= 1'b1;
      else if (wr_stat && wr_data[7]) seq_err_o <= 1'b0;
    end
  end

  // control flags live in the operation domain and clear on power-down
  always_ff @(posedge clk or posedge core_rst) begin
    if (core_rst) flags_o <= 2'b00;
    else if (wr_flag) flags_o <= wr_data[7:6];
  end

  a_r1_mode_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mode_o == MODE_RST));
  a_r8_seq_set: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == A_MODE && mode_o[B_PWR] && !wr_data[B_PWR]
     && (mode_o[B_TXE] || mode_o[B_RXE])) |=> seq_err_o);
  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    (seq_err_o && !(wr_en && wr_addr == A_STAT && wr_data[7])) |=> seq_err_o);
endmodule

// File: rtl/uart_pwr_rstgen.sv
module uart_pwr_rstgen #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr,
  output logic core_rst
);
  logic pwr_off;
  logic [SYNC-1:0] stg;

  assign pwr_off = ~pwr;

  // asserted at once when power drops, released after SYNC edges
  always_ff @(posedge clk or posedge pwr_off) begin
    if (pwr_off) stg <= '0;
    else         stg <= {stg[SYNC-2:0], 1'b1};
  end

  assign core_rst = ~stg[SYNC-1];

  a_r2_off_holds: assert property (@(posedge clk) disable iff (rst)
    !pwr |-> core_rst);
  a_r2_late_release: assert property (@(posedge clk) disable iff (rst)
    $rose(pwr) |-> core_rst);
endmodule

// File: rtl/uart_pwr_tx.sv
module uart_pwr_tx #(
  parameter int DIV = 16
) (
  input  logic       clk,
  input  logic       arst,
  input  logic       en,
  input  logic       load,
  input  logic [7:0] din,
  output logic       line_o,
  output logic       busy_o
);
  localparam int CW = $clog2(DIV);
  localparam logic [CW-1:0] CMAX = CW'(DIV - 1);

  logic [8:0]    sh;
  logic [3:0]    nb;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      sh <= '1; nb <= '0; cnt <= '0; line_o <= 1'b1; busy_o <= 1'b0;
    end else if (!en) begin
      sh <= '1; nb <= '0; cnt <= '0; line_o <= 1'b1; busy_o <= 1'b0;
    end else if (!busy_o) begin
      if (load) begin
        sh <= {1'b1, din}; nb <= 4'd9; cnt <= CMAX;
        line_o <= 1'b0; busy_o <= 1'b1;
      end
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end else if (nb == 4'd0) begin
      busy_o <= 1'b0;
    end else begin
      line_o <= sh[0];
      sh     <= {1'b1, sh[8:1]};
      nb     <= nb - 1'b1;
      cnt    <= CMAX;
    end
  end

  a_r9_idle_high: assert property (@(posedge clk) disable iff (arst)
    !en |=> (line_o && !busy_o));
  a_r10_start_low: assert property (@(posedge clk) disable iff (arst)
    (en && load && !busy_o) |=> !line_o);
endmodule

// File: rtl/uart_pwr_rx.sv
module uart_pwr_rx
  import uart_pwr_pkg::*;
#(
  parameter int DIV = 16
) (
  input  logic       clk,
  input  logic       arst,
  input  logic       en,
  input  logic       rxd,
  input  logic       rd_clr,
  input  logic       clr_ferr,
  input  logic       clr_ovr,
  output logic [7:0] data_o,
  output logic       valid_o,
  output logic       ferr_o,
  output logic       ovr_o
);
  localparam int CW = $clog2(DIV);
  localparam logic [CW-1:0] CMAX = CW'(DIV - 1);
  localparam logic [CW-1:0] HALF = CW'(DIV / 2 - 2);

  rx_st_e        st;
  logic [CW-1:0] cnt;
  logic [2:0]    idx;
  logic [7:0]    sh;
  logic          rin, stop_tick, store, bad;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) rin <= 1'b1;
    else      rin <= rxd;
  end

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      st <= RX_IDLE; cnt <= '0; idx <= '0; sh <= '0;
    end else if (!en) begin
      st <= RX_IDLE; cnt <= '0; idx <= '0; sh <= '0;
    end else begin
      case (st)
        RX_IDLE: if (!rin) begin st <= RX_START; cnt <= HALF; end
        RX_START:
          if (cnt != '0) cnt <= cnt - 1'b1;
          else if (!rin) begin st <= RX_DATA; cnt <= CMAX; idx <= '0; end
          else st <= RX_IDLE;
        RX_DATA:
          if (cnt != '0) cnt <= cnt - 1'b1;
          else begin
            sh  <= {rin, sh[7:1]};
            cnt <= CMAX;
            if (idx == 3'd7) st <= RX_STOP;
            else idx <= idx + 1'b1;
          end
        RX_STOP:
          if (cnt != '0) cnt <= cnt - 1'b1;
          else st <= rin ? RX_IDLE : RX_HOLD;
        RX_HOLD: if (rin) st <= RX_IDLE;
        default: st <= RX_IDLE;
      endcase
    end
  end

  assign stop_tick = en && (st == RX_STOP) && (cnt == '0);
  assign store     = stop_tick && rin;
  assign bad       = stop_tick && !rin;

  // buffer and error bits clear only on power-down or by software
  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      data_o <= '0; valid_o <= 1'b0; ferr_o <= 1'b0; ovr_o <= 1'b0;
    end else begin
      if (store) data_o <= sh;
      if (store) valid_o <= 1'b1;
      else if (rd_clr) valid_o <= 1'b0;
      if (store && valid_o && !rd_clr) ovr_o <= 1'b1;
      else if (clr_ovr) ovr_o <= 1'b0;
      if (bad) ferr_o <= 1'b1;
      else if (clr_ferr) ferr_o <= 1'b0;
    end
  end

  a_r11_overrun: assert property (@(posedge clk) disable iff (arst)
    (store && valid_o && !rd_clr) |=> ovr_o);
endmodule

// File: rtl/uart_pwr_ctrl.sv
module uart_pwr_ctrl
  import uart_pwr_pkg::*;
#(
  parameter int DIV  = 16,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  input  logic          rxd,
  output logic          txd,
  output logic          clk_run_o,
  output logic          tx_rst_o,
  output logic          rx_rst_o
);
  logic [7:0] mode;
  logic [1:0] flags;
  logic       seq_err, core_rst, tx_go, rx_go, rx_in;
  logic       tx_line, tx_busy, rx_valid, ferr, ovr;
  logic [7:0] rx_data, status;

  uart_pwr_regs u_regs (
    .clk(clk), .rst(rst), .core_rst(core_rst), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .mode_o(mode),
    .flags_o(flags), .seq_err_o(seq_err)
  );

  uart_pwr_rstgen #(.SYNC(SYNC)) u_rst (
    .clk(clk), .rst(rst), .pwr(mode[B_PWR]), .core_rst(core_rst)
  );

  assign tx_go     = mode[B_TXE] && !core_rst;
  assign rx_go     = mode[B_RXE] && !core_rst;
  assign tx_rst_o  = !tx_go;
  assign rx_rst_o  = !rx_go;
  assign clk_run_o = !core_rst;
  assign rx_in     = mode[B_PWR] ? rxd : 1'b1;

  uart_pwr_tx #(.DIV(DIV)) u_tx (
    .clk(clk), .arst(core_rst), .en(tx_go),
    .load(wr_en && wr_addr == A_TXB), .din(wr_data),
    .line_o(tx_line), .busy_o(tx_busy)
  );

  uart_pwr_rx #(.DIV(DIV)) u_rx (
    .clk(clk), .arst(core_rst), .en(rx_go), .rxd(rx_in),
    .rd_clr(rd_en && rd_addr == A_RXB),
    .clr_ferr(wr_en && wr_addr == A_STAT && wr_data[0]),
    .clr_ovr(wr_en && wr_addr == A_STAT && wr_data[1]),
    .data_o(rx_data), .valid_o(rx_valid), .ferr_o(ferr), .ovr_o(ovr)
  );

  assign txd    = tx_line;
  assign status = {seq_err, 2'b00, tx_busy, 1'b0, rx_valid, ovr, ferr};

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_en) begin
      case (rd_addr)
        A_MODE:  rd_data <= mode;
        A_FLAG:  rd_data <= {flags, 6'b0};
        A_STAT:  rd_data <= status;
        A_RXB:   rd_data <= rx_data;
        default: rd_data <= '0;
      endcase
    end
  end

  a_r5_txd_idle: assert property (@(posedge clk) disable iff (rst)
    !mode[B_PWR] |-> txd);
endmodule

// File: tb/sim_uart_pwr_ctrl.sv
`timescale 1ns/1ps
module sim_uart_pwr_ctrl;
  localparam int DIV = 4;
  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 0, rd_en = 0, rxd = 1;
  logic [2:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic txd, clk_run_o, tx_rst_o, rx_rst_o;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  uart_pwr_ctrl #(.DIV(DIV), .SYNC(2)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rxd(rxd), .txd(txd),
    .clk_run_o(clk_run_o), .tx_rst_o(tx_rst_o), .rx_rst_o(rx_rst_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1; rd_addr = a;
    @(negedge clk); rd_en = 0; d = rd_data;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [7:0] exp, input string req);
    logic [7:0] d;
    rd(a, d);
    chk(d == exp, req, d, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [9:0] frame_of(input logic [7:0] b, input bit stopv);
    return {stopv, b, 1'b0};
  endfunction

  // send a byte and sample the line mid-bit; expects a live transmitter
  task automatic tx_check(input logic [7:0] b, input string req);
    logic [9:0] got, exp;
    exp = frame_of(b, 1'b1);
    wr(3'd4, b);
    idle(DIV / 2);
    got[0] = txd;
    for (int k = 1; k < 10; k++) begin idle(DIV); got[k] = txd; end
    idle(DIV);
    chk(got == exp, req, got, exp);
  endtask

  // expects the line to stay high for a whole frame time
  task automatic tx_quiet(input logic [7:0] b, input string req);
    bit low = 0;
    wr(3'd4, b);
    for (int k = 0; k < 12 * DIV; k++) begin idle(1); if (!txd) low = 1; end
    chk(!low, req, low, 0);
  endtask

  task automatic rx_send(input logic [7:0] b, input bit stopv);
    logic [9:0] f;
    f = frame_of(b, stopv);
    for (int k = 0; k < 10; k++) begin @(negedge clk); rxd = f[k]; idle(DIV - 1); end
    @(negedge clk); rxd = 1'b1;
    idle(2 * DIV);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got %0h expected %0h", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] a, b;
    void'($urandom(32'd5150));
    idle(5); rst = 0; idle(1);
    // R1 reset state
    rd_chk(3'd0, 8'h01, "R1 mode reset");
    chk(txd && !clk_run_o && tx_rst_o && rx_rst_o, "R1 pins at reset", {txd, clk_run_o, tx_rst_o, rx_rst_o}, 4'b1011);
    wr(3'd0, 8'h0A); rd_chk(3'd0, 8'h0A, "R1 low bits storage");
    // R7 enables stored while unpowered
    wr(3'd0, 8'h61); rd_chk(3'd0, 8'h61, "R7 enable stored");
    idle(5);
    chk(tx_rst_o && rx_rst_o && !clk_run_o, "R7 directions inactive", {tx_rst_o, rx_rst_o, clk_run_o}, 3'b110);
    tx_quiet(8'h55, "R5 txd high unpowered");
    rx_send(8'h3C, 1'b1);                 // R5 ignored input
    // R2 power up with synchronized release
    wr(3'd0, 8'hE1);
    chk(!clk_run_o, "R2 held at write", clk_run_o, 0);
    idle(1); chk(!clk_run_o, "R2 held one edge", clk_run_o, 0);
    idle(1); chk(clk_run_o, "R2 released second edge", clk_run_o, 1);
    chk(!tx_rst_o && !rx_rst_o, "R7 directions active after power", {tx_rst_o, rx_rst_o}, 0);
    rd_chk(3'd2, 8'h00, "R5 no status from unpowered input");
    // R10 R11 directed and random loopback
    tx_check(8'h00, "R10 zeros");
    tx_check(8'hFF, "R10 ones");
    for (int i = 0; i < 6; i++) begin
      a = 8'($urandom);
      tx_check(a, "R10 random byte");
      b = 8'($urandom);
      rx_send(b, 1'b1);
      rd_chk(3'd2, 8'h04, "R11 valid set");
      rd_chk(3'd3, b, "R11 buffer");
      rd_chk(3'd2, 8'h00, "R11 valid cleared by read");
    end
    a = 8'($urandom); b = 8'($urandom);
    rx_send(a, 1'b1); rx_send(b, 1'b1);
    rd_chk(3'd2, 8'h06, "R11 overrun");
    rd_chk(3'd3, b, "R11 newest byte kept");
    wr(3'd2, 8'h03); rd_chk(3'd2, 8'h00, "R11 overrun cleared");
    rx_send(8'hA5, 1'b0);
    rd_chk(3'd2, 8'h01, "R11 framing error");
    wr(3'd2, 8'h01); rd_chk(3'd2, 8'h00, "R11 framing cleared");
    // R3 transmit disabled
    wr(3'd0, 8'hA1); idle(1);
    chk(tx_rst_o, "R3 tx reset out", tx_rst_o, 1);
    tx_quiet(8'h00, "R3 no frame when disabled");
    // R9 abandon mid-frame
    wr(3'd0, 8'hE1); idle(2);
    wr(3'd4, 8'h00); idle(2 * DIV);
    chk(!txd, "R9 frame running", txd, 0);
    wr(3'd0, 8'hA1); idle(1);
    chk(txd, "R9 txd high next clock", txd, 1);
    rd_chk(3'd2, 8'h00, "R9 busy cleared");
    // R4 receive disabled
    wr(3'd0, 8'hC1); idle(1);
    chk(rx_rst_o, "R4 rx reset out", rx_rst_o, 1);
    rx_send(8'h81, 1'b1);
    rd_chk(3'd2, 8'h00, "R4 nothing received");
    // R6 power-down clears state
    wr(3'd0, 8'hE1); idle(3);
    rx_send(8'h7E, 1'b1);
    rx_send(8'h11, 1'b0);
    wr(3'd1, 8'hC0); rd_chk(3'd1, 8'hC0, "R6 flags written");
    rd_chk(3'd2, 8'h05, "R6 status before power-down");
    wr(3'd0, 8'h81); wr(3'd0, 8'h01);
    rd_chk(3'd2, 8'h00, "R6 status cleared");
    rd_chk(3'd3, 8'h00, "R6 buffer cleared");
    rd_chk(3'd1, 8'h00, "R6 flags cleared");
    // R8 wrong stop order
    wr(3'd0, 8'hE1); idle(4);
    wr(3'd0, 8'h61);
    chk(!clk_run_o && txd, "R8 still powers down", {clk_run_o, txd}, 2'b01);
    rd_chk(3'd2, 8'h80, "R8 sequence error set");
    idle(3); rd_chk(3'd2, 8'h80, "R8 sequence error sticky");
    wr(3'd2, 8'h80); rd_chk(3'd2, 8'h00, "R8 sequence error cleared");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule